// File: doc/BRIEF.md
# Next-PC Unit with Optional Delay Slot

This block owns the program counter of a 32-bit fetch stage and chooses, every clock, the address to fetch next. From the current PC and the fetched instruction word it forms three candidates: the sequential address (PC + 4), a PC-relative branch target built from the 16-bit offset in the low half of the instruction, and a region-relative jump target built from the 26-bit index in the low bits of the instruction. Decode and register comparison happen elsewhere. The unit receives only three flags for the instruction now being fetched: whether it is a conditional branch, whether it is an unconditional jump, and whether the branch operands compared equal.

A mode input selects between immediate redirection and one-slot delayed redirection. In delayed mode a taken branch or jump does not move the PC at once. The unit advances to the next sequential word, which is the slot instruction, and holds the target in a pending register. It loads that target on the following advance. A stall input freezes both the PC and the pending state, and a synchronous reset returns the unit to address zero with nothing pending.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the PC becomes 0 and any pending target is discarded. A later non-redirecting instruction therefore advances the PC by exactly 4.
- R2: When no redirect is requested and nothing is pending, the PC advances to PC + 4 (modulo 2^32).
- R3: With `delay_en` low, a branch (`is_branch`=1, `is_jump`=0) with `cmp_eq`=1 loads PC + 4 + (sign-extended `instr[15:0]` × 4) on the next edge. Negative offsets and wrap-around follow 32-bit two's-complement arithmetic.
- R4: A branch with `cmp_eq`=0 is not taken. The PC advances to PC + 4 and no target is left pending in either mode.
- R5: With `delay_en` low, a jump loads {bits 31:28 of PC + 4, `instr[25:0]`, 2'b00} on the next edge. The upper four bits come from PC + 4, not from PC.
- R6: With `delay_en` high, a taken branch or jump first advances the PC to PC + 4, the slot instruction. The next non-stalled edge then loads the target that was computed from the redirecting instruction's own PC.
- R7: While a target is pending, the branch, jump and compare inputs of the slot instruction are ignored, and the pending target is loaded. The first target wins.
- R8: While `stall` is high (and `rst` low), the PC and the pending state keep their values.
- R9: When `is_branch` and `is_jump` are both high, the jump target is used.
- R10: A jump redirects regardless of the value of `cmp_eq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Hold PC and pending state |
| delay_en | input | 1 | 1 = one-slot delayed redirect, 0 = immediate |
| is_branch | input | 1 | Current instruction is a conditional branch |
| is_jump | input | 1 | Current instruction is an unconditional jump |
| cmp_eq | input | 1 | Branch operands are equal |
| instr | input | 32 | Fetched instruction word (offset in [15:0], index in [25:0]) |
| pc_o | output | 32 | Current program counter |
| next_pc_o | output | 32 | Address the PC loads at the next non-stalled edge |

## Verification
The delicate overlap is a slot instruction that is itself a taken branch or jump, arriving in the same cycle that the pending target is released. A stall can land on either side of that release. The bench sweeps every pair of consecutive control patterns (branch, jump, equal, delay mode, stall), so redirects in the slot, stalls during a pending slot and mode flips while pending all occur. After each edge it compares the PC with an arithmetic model in which the older target must win and a stall must leave the release for a later edge. Directed cases add offsets at the sign boundary and a jump that crosses a 256 MB region, so that the upper bits are taken from PC + 4.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int XLEN    = 32;
    localparam int OFF_W   = 16;
    localparam int JIDX_W  = 26;
    localparam int WSHIFT  = 2;
    localparam int REGION_W = XLEN - JIDX_W - WSHIFT;

    typedef logic [XLEN-1:0] addr_t;

    typedef struct packed {
        addr_t seq;
        addr_t br;
        addr_t jmp;
    } tgt_set_t;

    typedef struct packed {
        logic  valid;
        addr_t addr;
    } pend_t;

    typedef enum logic [1:0] {
        SEL_SEQ     = 2'd0,
        SEL_NOW     = 2'd1,
        SEL_PENDING = 2'd2
    } sel_e;

    function automatic addr_t word_offset(input logic [OFF_W-1:0] off);
        addr_t ext;
        ext = {{(XLEN-OFF_W){off[OFF_W-1]}}, off};
        return ext << WSHIFT;
    endfunction

    function automatic addr_t region_target(input addr_t pc4,
                                            input logic [JIDX_W-1:0] idx);
        return {pc4[XLEN-1 -: REGION_W], idx, {WSHIFT{1'b0}}};
    endfunction

endpackage

// File: rtl/npc_target_gen.sv
module npc_target_gen
    import npc_pkg::*;
#(
    parameter int STEP = 4
) (
    input  addr_t              pc,
    input  logic [XLEN-1:0]    instr,
    output tgt_set_t           tgts
);
    addr_t pc_next_word;

    always_comb begin
        pc_next_word = pc + addr_t'(STEP);
        tgts.seq     = pc_next_word;
        tgts.br      = pc_next_word + word_offset(instr[OFF_W-1:0]);
        tgts.jmp     = region_target(pc_next_word, instr[JIDX_W-1:0]);
    end
endmodule

// File: rtl/npc_redirect_ctl.sv
module npc_redirect_ctl
    import npc_pkg::*;
(
    input  logic     is_branch,
    input  logic     is_jump,
    input  logic     cmp_eq,
    input  logic     delay_en,
    input  pend_t    pend_q,
    input  tgt_set_t tgts,
    output sel_e     sel,
    output addr_t    next_pc,
    output pend_t    pend_d
);
    logic  want_redirect;
    addr_t chosen_tgt;

    always_comb begin
        want_redirect = is_jump | (is_branch & cmp_eq);
        chosen_tgt    = is_jump ? tgts.jmp : tgts.br;

        sel    = SEL_SEQ;
        pend_d = '0;

        if (pend_q.valid) begin
            sel = SEL_PENDING;
        end else if (want_redirect && delay_en) begin
            sel         = SEL_SEQ;
            pend_d.valid = 1'b1;
            pend_d.addr  = chosen_tgt;
        end else if (want_redirect) begin
            sel = SEL_NOW;
        end

        unique case (sel)
            SEL_PENDING: next_pc = pend_q.addr;
            SEL_NOW:     next_pc = chosen_tgt;
            default:     next_pc = tgts.seq;
        endcase
    end
endmodule

// File: rtl/npc_state.sv
module npc_state
    import npc_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  stall,
    input  addr_t next_pc,
    input  pend_t pend_d,
    output addr_t pc_q,
    output pend_t pend_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= RESET_PC;
            pend_q <= '0;
        end else if (!stall) begin
            pc_q   <= next_pc;
            pend_q <= pend_d;
        end
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = '0,
    parameter int              STEP     = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            stall,
    input  logic            delay_en,
    input  logic            is_branch,
    input  logic            is_jump,
    input  logic            cmp_eq,
    input  logic [XLEN-1:0] instr,
    output logic [XLEN-1:0] pc_o,
    output logic [XLEN-1:0] next_pc_o
);
    addr_t    pc_q;
    addr_t    next_pc;
    pend_t    pend_q;
    pend_t    pend_d;
    tgt_set_t tgts;
    sel_e     sel;
    logic     pend_valid;

    npc_target_gen #(.STEP(STEP)) u_tgen (
        .pc    (pc_q),
        .instr (instr),
        .tgts  (tgts)
    );

    npc_redirect_ctl u_ctl (
        .is_branch (is_branch),
        .is_jump   (is_jump),
        .cmp_eq    (cmp_eq),
        .delay_en  (delay_en),
        .pend_q    (pend_q),
        .tgts      (tgts),
        .sel       (sel),
        .next_pc   (next_pc),
        .pend_d    (pend_d)
    );

    npc_state #(.RESET_PC(RESET_PC)) u_state (
        .clk     (clk),
        .rst     (rst),
        .stall   (stall),
        .next_pc (next_pc),
        .pend_d  (pend_d),
        .pc_q    (pc_q),
        .pend_q  (pend_q)
    );

    assign pend_valid = pend_q.valid;
    assign pc_o       = pc_q;
    assign next_pc_o  = next_pc;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
    import npc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        stall,
    input logic        delay_en,
    input logic        is_branch,
    input logic        is_jump,
    input logic        cmp_eq,
    input logic [XLEN-1:0] pc_o,
    input logic        pend_valid
);
    logic redir;
    assign redir = is_jump | (is_branch & cmp_eq);

    assert_reset_pc_R1: assert property (@(posedge clk)
        rst |=> (pc_o == '0 && !pend_valid));

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!stall && !pend_valid && !is_branch && !is_jump)
        |=> pc_o == $past(pc_o) + addr_t'(4));

    assert_not_taken_R4: assert property (@(posedge clk) disable iff (rst)
        (!stall && !pend_valid && is_branch && !is_jump && !cmp_eq)
        |=> (pc_o == $past(pc_o) + addr_t'(4) && !pend_valid));

    assert_slot_first_R6: assert property (@(posedge clk) disable iff (rst)
        (!stall && !pend_valid && delay_en && redir)
        |=> (pc_o == $past(pc_o) + addr_t'(4) && pend_valid));

    assert_pending_release_R7: assert property (@(posedge clk) disable iff (rst)
        (!stall && pend_valid) |=> !pend_valid);

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(pc_o) && $stable(pend_valid)));

    assert_pc_aligned_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> pc_o[1:0] == 2'b00);
endmodule

bind npc_unit npc_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .stall      (stall),
    .delay_en   (delay_en),
    .is_branch  (is_branch),
    .is_jump    (is_jump),
    .cmp_eq     (cmp_eq),
    .pc_o       (pc_o),
    .pend_valid (pend_valid)
);

// File: tb/tb_npc_unit.sv
module tb_npc_unit;
    logic        clk = 1'b0;
    logic        rst, stall, delay_en, is_branch, is_jump, cmp_eq;
    logic [31:0] instr;
    logic [31:0] pc_o, next_pc_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [31:0] m_pc;
    logic        m_pend;
    logic [31:0] m_tgt;

    always #2.5 clk = ~clk;

    npc_unit dut (
        .clk(clk), .rst(rst), .stall(stall), .delay_en(delay_en),
        .is_branch(is_branch), .is_jump(is_jump), .cmp_eq(cmp_eq),
        .instr(instr), .pc_o(pc_o), .next_pc_o(next_pc_o)
    );

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; stall = 0; delay_en = 0; is_branch = 0; is_jump = 0;
        cmp_eq = 0; instr = '0;
        @(posedge clk); #1;
        rst = 1'b0;
        m_pc = 0; m_pend = 0; m_tgt = 0;
    endtask

    // One clock with given controls; model from the requirements, then compare.
    task automatic step(input logic br, input logic jp, input logic eq,
                        input logic dly, input logic stl, input logic [31:0] iw);
        logic [31:0] pc4, bt, jt, tgt, npc;
        logic        redir;
        string       tag;
        is_branch = br; is_jump = jp; cmp_eq = eq; delay_en = dly;
        stall = stl; instr = iw;
        pc4   = m_pc + 32'd4;
        bt    = pc4 + ({{16{iw[15]}}, iw[15:0]} << 2);
        jt    = {pc4[31:28], iw[25:0], 2'b00};
        redir = jp | (br & eq);
        tgt   = jp ? jt : bt;
        npc   = m_pc;
        if (stl) tag = "R8";
        else if (m_pend) tag = redir ? "R7" : "R6";
        else if (redir && dly) tag = "R6";
        else if (jp && br) tag = "R9";
        else if (jp && !eq) tag = "R10";
        else if (jp) tag = "R5";
        else if (br && eq) tag = "R3";
        else if (br) tag = "R4";
        else tag = "R2";
        if (!stl) begin
            if (m_pend) begin
                npc = m_tgt; m_pend = 0;
            end else if (redir && dly) begin
                npc = pc4; m_pend = 1; m_tgt = tgt;
            end else if (redir) begin
                npc = tgt;
            end else begin
                npc = pc4;
            end
        end
        @(posedge clk); #1;
        m_pc = npc;
        check(tag, pc_o, m_pc);
    endtask

    initial begin
        do_reset();
        check("R1", pc_o, 32'h0);
        step(0, 0, 0, 0, 0, 32'h0);
        check("R1", pc_o, 32'h4);

        // R3 offset boundaries, immediate mode
        step(1, 0, 1, 0, 0, 32'h0000_7FFF);   // pc 4 -> 8 + 0x1FFFC
        check("R3", pc_o, 32'h0002_0004);
        step(1, 0, 1, 0, 0, 32'h0000_FFFF);   // back by one word -> same pc
        check("R3", pc_o, 32'h0002_0004);
        step(1, 0, 1, 0, 0, 32'h0000_8000);   // -0x20000
        check("R3", pc_o, 32'h0000_0008);

        // R5 region crossing: go to 0x0FFFFFFC then jump with index 0
        step(0, 1, 0, 0, 0, 32'h03FF_FFFF);
        check("R5", pc_o, 32'h0FFF_FFFC);
        step(0, 1, 0, 0, 0, 32'h0000_0000);
        check("R5", pc_o, 32'h1000_0000);

        // R6 / R7 directed: delayed jump, slot holds a branch that is ignored
        step(0, 1, 1, 1, 0, 32'h0000_0100);
        check("R6", pc_o, 32'h1000_0004);
        step(1, 0, 1, 1, 0, 32'h0000_0040);
        check("R7", pc_o, 32'h1000_0400);

        // R1: reset clears a pending target
        step(1, 0, 1, 1, 0, 32'h0000_0010);
        do_reset();
        check("R1", pc_o, 32'h0);
        step(0, 0, 0, 1, 0, 32'h0);
        check("R1", pc_o, 32'h4);

        // Sweep every pair of consecutive control patterns
        for (int a = 0; a < 32; a++) begin
            for (int b = 0; b < 32; b++) begin
                logic [31:0] w1, w2;
                w1 = 32'(a) * 32'h9E37_79B1 ^ 32'(b) * 32'h0001_0003;
                w2 = 32'(b) * 32'h7F4A_7C15 ^ 32'(a) * 32'h0000_0101;
                step(a[0], a[1], a[2], a[3], a[4], w1);
                step(b[0], b[1], b[2], b[3], b[4], w2);
            end
        end

        // Stall while pending, then release
        do_reset();
        step(1, 0, 1, 1, 0, 32'h0000_0020);
        step(0, 0, 0, 1, 1, 32'h0);
        check("R8", pc_o, 32'h0000_0004);
        step(0, 0, 0, 0, 0, 32'h0);
        check("R6", pc_o, 32'h0000_0084);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule